// File: doc/BRIEF.md
# Coefficient RAM Readback Window

This block lets a host read a 24-bit coefficient RAM over a byte-wide register interface. An I2C-style target front end drives that interface. The block owns the register address pointer. A front end loads the pointer with the register-address byte of a write cycle. The pointer then steps forward after every data byte the host writes and after every read byte the host acknowledges.

Four consecutive registers form the window:
- A pointer register holds the RAM word index.
- Three byte registers return the low, middle and high slices of a holding register.

A write to the pointer register loads the RAM index. It also starts a prefetch of that word through a fixed-latency RAM. A complete low, middle, high read sequence advances the RAM index and prefetches the next word. This lets a host stream consecutive words with a register-address write, a repeated start and a three-byte read per word.

The behavioural RAM model is part of the block. Its contents are computed when the design is elaborated: word `i` holds `(i * PAT_MUL + PAT_ADD) mod 2^24`.

Top module: `coef_readback_window`

## Requirements
- R1: After a synchronous reset, `rd_byte` is 0, `pf_busy` is 0, the RAM index is 0 and the holding word is 0.
- R2: A data byte written while the register pointer equals `PTR_REG` (default 0x7C) loads the RAM index with the byte modulo `RAM_DEPTH`. It also starts a prefetch of that word. Reading register `PTR_REG` returns the RAM index.
- R3: Registers `PTR_REG+1`, `PTR_REG+2` and `PTR_REG+3` return bits 7:0, 15:8 and 23:16 of the holding word. `rd_byte` shows the register selected by the pointer one cycle after the pointer settles.
- R4: The register pointer increments by one after each `wd_valid` and after each `rd_next`. A `ra_load` pulse replaces the pointer with `ra_value`.
- R5: An acknowledged read of the high register advances the RAM index by one and prefetches the new word. This applies only when it completes an acknowledged low, then middle sequence with no pointer load or write in between.
- R6: The RAM index wraps from `RAM_DEPTH-1` to 0 when it advances.
- R7: An acknowledged read of the low or middle register leaves the RAM index unchanged. So does a high read without the preceding low and middle acks. Such a high read still returns the current high slice.
- R8: `pf_busy` rises the cycle after a prefetch trigger. It stays high for `RAM_LAT+1` cycles. The holding word changes only when the RAM returns data.
- R9: When a newer prefetch supersedes an older one, only the word for the current RAM index is latched.
- R10: A RAM word at index `i` equals `(i * PAT_MUL + PAT_ADD) mod 2^24`. Defaults: `PAT_MUL=0x010203`, `PAT_ADD=0x5A3C1E`.
- R11: A data write to the low, middle, high or any unmapped register changes neither the RAM index nor the holding word. Reads of unmapped registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_load | input | 1 | Load the register pointer with `ra_value` |
| ra_value | input | 8 | Register address byte from the write cycle |
| wd_valid | input | 1 | A data byte is written at the register pointer |
| wd_byte | input | 8 | Written data byte |
| rd_next | input | 1 | Host acknowledged the current read byte |
| rd_byte | output | 8 | Registered contents of the selected register |
| pf_busy | output | 1 | A prefetch is outstanding |

## Verification
The assertions check every cycle that:
- the register pointer steps after each acknowledge;
- the RAM index wraps and stays put on low or middle acks;
- the holding word changes only on a RAM return for the wanted index.

Only the bench scenarios can show the following:
- the returned bytes match the arithmetic word pattern across all 128 indices;
- streaming across the wrap point works;
- superseded prefetches are discarded;
- writes to the data registers are ignored.

// File: rtl/crw_pkg.sv
package crw_pkg;
  localparam int RA_W   = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 24;

  typedef enum logic [2:0] {
    SEL_OTHER = 3'd0,
    SEL_PTR   = 3'd1,
    SEL_LO    = 3'd2,
    SEL_MID   = 3'd3,
    SEL_HI    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/crw_coef_ram.sv
module crw_coef_ram
  import crw_pkg::*;
#(
  parameter int          DEPTH   = 128,
  parameter int          LAT     = 2,
  parameter logic [23:0] PAT_MUL = 24'h010203,
  parameter logic [23:0] PAT_ADD = 24'h5A3C1E,
  localparam int         AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_tag,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [LAT-1:0]    v_q;
  logic [AW-1:0]     a_q [LAT];
  logic [WORD_W-1:0] d_q [LAT];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = WORD_W'(PAT_MUL * i + PAT_ADD);
    end
  end

  // valid pipeline carries reset; data pipeline does not (block RAM friendly)
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      v_q[0] <= rd_en;
      for (int s = 1; s < LAT; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      d_q[0] <= mem[rd_addr];
      a_q[0] <= rd_addr;
    end
    for (int s = 1; s < LAT; s++) begin
      d_q[s] <= d_q[s-1];
      a_q[s] <= a_q[s-1];
    end
  end

  assign rd_valid = v_q[LAT-1];
  assign rd_tag   = a_q[LAT-1];
  assign rd_data  = d_q[LAT-1];
endmodule

// File: rtl/crw_prefetch.sv
module crw_prefetch
  import crw_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [AW-1:0]     trig_addr,
  output logic              ram_req,
  output logic [AW-1:0]     ram_req_addr,
  input  logic              ram_valid,
  input  logic [AW-1:0]     ram_tag,
  input  logic [WORD_W-1:0] ram_data,
  output logic [WORD_W-1:0] hold_word,
  output logic              busy
);
  logic [AW-1:0] want_q;
  logic          hit;

  assign hit = ram_valid && busy && (ram_tag == want_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_req      <= 1'b0;
      ram_req_addr <= '0;
      want_q       <= '0;
      busy         <= 1'b0;
      hold_word    <= '0;
    end else begin
      ram_req <= trig;
      if (trig) begin
        ram_req_addr <= trig_addr;
        want_q       <= trig_addr;
      end
      if (trig)     busy <= 1'b1;
      else if (hit) busy <= 1'b0;
      if (hit && !trig) hold_word <= ram_data;
    end
  end

  // R8
  hold_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(hold_word) |-> $past(ram_valid));
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> busy);
  // R9
  stale_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_valid && ram_tag != want_q) |=> $stable(hold_word));
endmodule

// File: rtl/crw_regs.sv
module crw_regs
  import crw_pkg::*;
#(
  parameter int          DEPTH   = 128,
  parameter logic [7:0]  PTR_REG = 8'h7C,
  localparam int         AW      = $clog2(DEPTH),
  localparam logic [7:0] LO_REG  = PTR_REG + 8'd1,
  localparam logic [7:0] MID_REG = PTR_REG + 8'd2,
  localparam logic [7:0] HI_REG  = PTR_REG + 8'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ra_load,
  input  logic [RA_W-1:0]   ra_value,
  input  logic              wd_valid,
  input  logic [BYTE_W-1:0] wd_byte,
  input  logic              rd_next,
  input  logic [WORD_W-1:0] hold_word,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              trig,
  output logic [AW-1:0]     trig_addr
);
  logic [RA_W-1:0] reg_ptr;
  logic [AW-1:0]   cptr;
  logic            lo_run;
  reg_sel_e        sel;
  logic            load_idx, adv_idx;
  logic [AW-1:0]   idx_inc;

  always_comb begin
    unique case (reg_ptr)
      PTR_REG: sel = SEL_PTR;
      LO_REG:  sel = SEL_LO;
      MID_REG: sel = SEL_MID;
      HI_REG:  sel = SEL_HI;
      default: sel = SEL_OTHER;
    endcase
  end

  assign idx_inc  = (cptr == AW'(DEPTH - 1)) ? '0 : cptr + 1'b1;
  assign load_idx = !ra_load && wd_valid && (sel == SEL_PTR);
  assign adv_idx  = !ra_load && !wd_valid && rd_next && (sel == SEL_HI) && lo_run;
  assign trig     = load_idx || adv_idx;
  assign trig_addr = load_idx ? AW'(32'(wd_byte) % DEPTH) : idx_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ptr <= '0;
      cptr    <= '0;
      lo_run  <= 1'b0;
      rd_byte <= '0;
    end else begin
      if (ra_load)                  reg_ptr <= ra_value;
      else if (wd_valid || rd_next) reg_ptr <= reg_ptr + 1'b1;

      if (trig) cptr <= trig_addr;

      if (ra_load || wd_valid)       lo_run <= 1'b0;
      else if (rd_next) begin
        if (sel == SEL_LO)           lo_run <= 1'b1;
        else if (sel != SEL_MID)     lo_run <= 1'b0;
      end

      unique case (sel)
        SEL_PTR: rd_byte <= BYTE_W'(cptr);
        SEL_LO:  rd_byte <= hold_word[7:0];
        SEL_MID: rd_byte <= hold_word[15:8];
        SEL_HI:  rd_byte <= hold_word[23:16];
        default: rd_byte <= '0;
      endcase
    end
  end

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_next && !ra_load) |=> reg_ptr == $past(reg_ptr) + 8'd1);
  // R6
  idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_idx && cptr == AW'(DEPTH - 1)) |=> cptr == '0);
  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_next && !wd_valid && sel != SEL_HI) |=> $stable(cptr));
  // R5
  idx_adv_chk: assert property (@(posedge clk) disable iff (rst)
    adv_idx |=> cptr != $past(cptr));
endmodule

// File: rtl/coef_readback_window.sv
module coef_readback_window
  import crw_pkg::*;
#(
  parameter int          RAM_DEPTH = 128,
  parameter int          RAM_LAT   = 2,
  parameter logic [7:0]  PTR_REG   = 8'h7C,
  parameter logic [23:0] PAT_MUL   = 24'h010203,
  parameter logic [23:0] PAT_ADD   = 24'h5A3C1E,
  localparam int         AW        = $clog2(RAM_DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ra_load,
  input  logic [7:0] ra_value,
  input  logic       wd_valid,
  input  logic [7:0] wd_byte,
  input  logic       rd_next,
  output logic [7:0] rd_byte,
  output logic       pf_busy
);
  logic              trig;
  logic [AW-1:0]     trig_addr;
  logic              ram_req;
  logic [AW-1:0]     ram_req_addr;
  logic              ram_valid;
  logic [AW-1:0]     ram_tag;
  logic [WORD_W-1:0] ram_data;
  logic [WORD_W-1:0] hold_word;

  crw_regs #(.DEPTH(RAM_DEPTH), .PTR_REG(PTR_REG)) u_regs (
    .clk(clk), .rst(rst), .ra_load(ra_load), .ra_value(ra_value),
    .wd_valid(wd_valid), .wd_byte(wd_byte), .rd_next(rd_next),
    .hold_word(hold_word), .rd_byte(rd_byte),
    .trig(trig), .trig_addr(trig_addr));

  crw_prefetch #(.AW(AW)) u_pf (
    .clk(clk), .rst(rst), .trig(trig), .trig_addr(trig_addr),
    .ram_req(ram_req), .ram_req_addr(ram_req_addr),
    .ram_valid(ram_valid), .ram_tag(ram_tag), .ram_data(ram_data),
    .hold_word(hold_word), .busy(pf_busy));

  crw_coef_ram #(.DEPTH(RAM_DEPTH), .LAT(RAM_LAT),
                 .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_ram (
    .clk(clk), .rst(rst), .rd_en(ram_req), .rd_addr(ram_req_addr),
    .rd_valid(ram_valid), .rd_tag(ram_tag), .rd_data(ram_data));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_byte == 8'd0 && !pf_busy));
endmodule

// File: tb/test_coef_readback_window.sv
module test_coef_readback_window;
  localparam int         DEPTH = 128;
  localparam int         LAT   = 2;
  localparam logic [7:0] PREG  = 8'h7C;
  localparam logic [7:0] LOR   = PREG + 8'd1;
  localparam logic [7:0] MIDR  = PREG + 8'd2;
  localparam logic [7:0] HIR   = PREG + 8'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ra_load = 1'b0, wd_valid = 1'b0, rd_next = 1'b0;
  logic [7:0] ra_value = '0, wd_byte = '0;
  logic [7:0] rd_byte;
  logic pf_busy;
  int tests = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  coef_readback_window i_coef_readback_window (
    .clk(clk), .rst(rst), .ra_load(ra_load), .ra_value(ra_value),
    .wd_valid(wd_valid), .wd_byte(wd_byte), .rd_next(rd_next),
    .rd_byte(rd_byte), .pf_busy(pf_busy));

  function automatic logic [23:0] word_at(int i);
    return 24'(24'h010203 * i + 24'h5A3C1E);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_ra(logic [7:0] v);
    ra_load = 1'b1; ra_value = v;
    @(negedge clk); ra_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    wd_valid = 1'b1; wd_byte = b;
    @(negedge clk); wd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack;
    rd_next = 1'b1;
    @(negedge clk); rd_next = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle;
    while (pf_busy) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic set_idx(logic [7:0] b);
    set_ra(PREG); wr(b); idle;
  endtask

  // read one word through LO, MID, HI with checks
  task automatic read_word(int idx, string req);
    logic [23:0] w;
    w = word_at(idx);
    set_ra(LOR);  check(req, rd_byte, w[7:0]);   ack;
    check(req, rd_byte, w[15:8]); ack;
    check(req, rd_byte, w[23:16]); ack;
    idle;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", rd_byte, 8'h00);
    check("R1", {7'd0, pf_busy}, 8'h00);
    set_ra(PREG); @(negedge clk);
    check("R1", rd_byte, 8'h00);
    set_ra(LOR); @(negedge clk);
    check("R1", rd_byte, 8'h00);

    // R8 busy window length
    set_ra(PREG);
    wd_valid = 1'b1; wd_byte = 8'd3;
    @(negedge clk); wd_valid = 1'b0;
    n = 0;
    while (pf_busy) begin n++; @(negedge clk); end
    check("R8", 8'(n), 8'(LAT + 1));
    @(negedge clk);

    // sweep: R2 R3 R4 R5 R6 R10
    for (int a = 0; a < DEPTH; a++) begin
      logic [23:0] w;
      w = word_at(a);
      set_idx(8'(a));
      // R4: write stepped register pointer to LO
      check("R4", rd_byte, w[7:0]);
      set_ra(PREG); @(negedge clk);
      check("R2", rd_byte, 8'(a));
      read_word(a, "R10");
      set_ra(PREG); @(negedge clk);
      check("R5", rd_byte, 8'((a + 1) % DEPTH));
    end

    // R2 modulo load
    set_idx(8'd200);
    set_ra(PREG); @(negedge clk);
    check("R2", rd_byte, 8'(200 % DEPTH));

    // R6 streaming across the wrap
    set_idx(8'd125);
    for (int k = 0; k < 6; k++) read_word((125 + k) % DEPTH, "R6");
    set_ra(PREG); @(negedge clk);
    check("R6", rd_byte, 8'd3);

    // R7 middle/high reads without a leading low read
    set_idx(8'd10);
    set_ra(MIDR); check("R7", rd_byte, word_at(10)[15:8]); ack;
    check("R7", rd_byte, word_at(10)[23:16]); ack; idle;
    set_ra(HIR); check("R7", rd_byte, word_at(10)[23:16]); ack; idle;
    set_ra(PREG); @(negedge clk);
    check("R7", rd_byte, 8'd10);

    // R11 writes to data and unmapped registers ignored
    set_ra(LOR); wr(8'hFF); wr(8'h00); wr(8'h55); idle;
    set_ra(8'h10); wr(8'h33); idle;
    set_ra(PREG); @(negedge clk);
    check("R11", rd_byte, 8'd10);
    set_ra(LOR); @(negedge clk);
    check("R11", rd_byte, word_at(10)[7:0]);
    set_ra(8'h10); @(negedge clk);
    check("R11", rd_byte, 8'h00);

    // R9 superseded prefetch
    set_ra(PREG);
    wd_valid = 1'b1; wd_byte = 8'd5;
    @(negedge clk); wd_valid = 1'b0;
    ra_load = 1'b1; ra_value = PREG;
    @(negedge clk); ra_load = 1'b0;
    wd_valid = 1'b1; wd_byte = 8'd9;
    @(negedge clk); wd_valid = 1'b0;
    idle;
    check("R9", rd_byte, word_at(9)[7:0]);
    set_ra(MIDR); @(negedge clk);
    check("R9", rd_byte, word_at(9)[15:8]);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule